// File: doc/BRIEF.md
# Correlating (m,n) Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a global shift register holding the outcomes of the most recent `HIST_W` resolved branches, and a table of `CTR_W`-bit saturating counters. The table is organised as `2**ROW_BITS` rows, and each row holds `2**HIST_W` counters. A field of the branch address picks the row. The current global history picks one counter inside that row. The most significant bit of that counter is the prediction. Because of this, the recent behaviour of other branches decides which of several per-address predictors answers.

The prediction port is a purely combinational lookup. It takes a PC and returns the prediction together with the history value that was used. The caller keeps that history snapshot with the branch. When the branch resolves, the caller presents the PC, the real outcome and the saved snapshot on the update port. The block then adjusts exactly the counter that made the prediction, and shifts the outcome into the global history.

The update port follows valid/ready rules. A transfer happens on a rising clock edge where `upd_valid` and `upd_ready` are both high. The block never applies back-pressure, so `upd_ready` is held high whenever it is out of reset. A producer may therefore issue one update every cycle. While `upd_valid` is low, the update inputs are ignored.

Top module: `corr_bpred`

## Requirements
- R1: After reset, the global history is 0 and every counter holds the weakly-not-taken value 2**(CTR_W-1)-1 (01 for 2-bit counters), so every lookup predicts not taken (`pred_taken`=0) and reports `pred_hist`=0.
- R2: `pred_taken` is combinational and equals the most significant bit of the counter at row `pred_pc[PC_LSB +: ROW_BITS]` and column equal to the current history; `pred_hist` shows that current history.
- R3: An accepted update with `upd_taken`=1 increments the selected counter, saturating at 2**CTR_W-1.
- R4: An accepted update with `upd_taken`=0 decrements the selected counter, saturating at 0.
- R5: An accepted update changes only the counter at row `upd_pc[PC_LSB +: ROW_BITS]` and column `upd_hist`; all other counters keep their values.
- R6: An accepted update shifts the global history left by one and places `upd_taken` (1 = taken, 0 = not taken) in bit 0, so bit 0 is the newest outcome and the oldest bit is dropped.
- R7: The counter column on update comes from `upd_hist`, not from the current history, even if the history has moved on since the prediction was made.
- R8: `upd_ready` is 1 out of reset. With `upd_valid`=0, neither the history nor any counter changes.
- R9: With 2-bit counters, a branch held at strongly taken keeps predicting taken after one not-taken outcome, and flips to not taken only after a second one.
- R10: PC bits outside `pred_pc[PC_LSB +: ROW_BITS]` (or the same field of `upd_pc`) have no effect on row selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this lookup; keep it for the update |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Update accepted when high together with upd_valid |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History snapshot taken at prediction time |

## Verification
The main stimulus is a long pseudo-random stream of updates. Each update has a random row, random upper PC bits, a random outcome and a random stale history snapshot. After every update, all rows are swept at the current history and compared with an arithmetic model. This separates correct row and column selection (R2, R5, R7, R10) from aliasing, and it drives counters into both saturation limits (R3, R4). A directed sequence first builds a strongly-taken counter and then feeds it two not-taken outcomes, showing the hysteresis of R9. A burst of cycles with the update inputs active but `upd_valid` low shows that the history and the lookups stay unchanged (R8).

// File: rtl/corr_bpred_pkg.sv
`timescale 1ns/1ps
package corr_bpred_pkg;

  typedef enum logic {
    OUT_NOT_TAKEN = 1'b0,
    OUT_TAKEN     = 1'b1
  } outcome_e;

  // Weakly-not-taken starting value for a counter of the given width.
  function automatic int weak_nt(input int width);
    return (1 << (width - 1)) - 1;
  endfunction

endpackage

// File: rtl/cbp_ghist.sv
`timescale 1ns/1ps
module cbp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W:0]   shifted;

  // Append the newest outcome at bit 0; the top bit falls off.
  assign shifted = {hist_q, outcome};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= shifted[HIST_W-1:0];
    end
  end

  assign hist = hist_q;

endmodule

// File: rtl/cbp_sat_step.sv
`timescale 1ns/1ps
module cbp_sat_step #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             up,
  output logic [CTR_W-1:0] nxt
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;
  localparam logic [CTR_W-1:0] ONE     = CTR_W'(1);

  always_comb begin
    nxt = cur;
    if (up) begin
      if (cur != CTR_MAX) nxt = cur + ONE;
    end else begin
      if (cur != CTR_MIN) nxt = cur - ONE;
    end
  end

endmodule

// File: rtl/cbp_ctr_table.sv
`timescale 1ns/1ps
module cbp_ctr_table
  import corr_bpred_pkg::*;
#(
  parameter int CTR_W  = 2,
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(weak_nt(CTR_W));

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;
  logic [CTR_W-1:0] rd_val;

  assign rd_val = ctr_q[rd_idx];
  assign rd_msb = rd_val[CTR_W-1];
  assign wr_cur = ctr_q[wr_idx];

  cbp_sat_step #(.CTR_W(CTR_W)) u_step (
    .cur (wr_cur),
    .up  (wr_up),
    .nxt (wr_nxt)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctr_q[e] <= CTR_INIT;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ctr_q[e] <= wr_nxt;
      end
    end
  end

endmodule

// File: rtl/corr_bpred.sv
`timescale 1ns/1ps
module corr_bpred
  import corr_bpred_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int ROW_BITS = 4,
  parameter int HIST_W   = 2,
  parameter int CTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  localparam int IDX_W = ROW_BITS + HIST_W;

  logic [HIST_W-1:0]   hist_cur;
  logic [ROW_BITS-1:0] rd_row;
  logic [ROW_BITS-1:0] wr_row;
  logic [IDX_W-1:0]    rd_idx;
  logic [IDX_W-1:0]    wr_idx;
  logic                upd_fire;
  logic                rdy_q;
  outcome_e            upd_outcome;

  // Ready rises once reset is released; the block never stalls updates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign upd_ready   = rdy_q;
  assign upd_fire    = upd_valid && rdy_q;
  assign upd_outcome = outcome_e'(upd_taken);

  assign rd_row = pred_pc[PC_LSB +: ROW_BITS];
  assign wr_row = upd_pc[PC_LSB +: ROW_BITS];
  assign rd_idx = {rd_row, hist_cur};
  assign wr_idx = {wr_row, upd_hist};

  cbp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_fire),
    .outcome  (upd_outcome == OUT_TAKEN),
    .hist     (hist_cur)
  );

  cbp_ctr_table #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (rd_idx),
    .rd_msb (pred_taken),
    .wr_en  (upd_fire),
    .wr_idx (wr_idx),
    .wr_up  (upd_outcome == OUT_TAKEN)
  );

  assign pred_hist = hist_cur;

endmodule

// File: rtl/corr_bpred_chk.sv
`timescale 1ns/1ps
module corr_bpred_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_ready,
  input logic              upd_taken
);

  logic [HIST_W:0] hist_cat;
  assign hist_cat = {pred_hist, upd_taken};

  // R1: history is clear in the first cycle after reset release
  assert_reset_hist_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_ready) |-> (pred_hist == '0));

  // R6: accepted update shifts the outcome into bit 0
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (pred_hist == $past(hist_cat[HIST_W-1:0])));

  // R8: no accepted update leaves the history alone
  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_ready) |=> $stable(pred_hist));

  // R8: without an update, an unchanged lookup gives an unchanged answer
  assert_pred_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_ready) |=> ($stable(pred_pc) -> $stable(pred_taken)));

endmodule

bind corr_bpred corr_bpred_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .pred_hist  (pred_hist),
  .upd_valid  (upd_valid),
  .upd_ready  (upd_ready),
  .upd_taken  (upd_taken)
);

// File: tb/corr_bpred_bench.sv
`timescale 1ns/1ps
module corr_bpred_bench;

  localparam int PC_W = 32, PC_LSB = 2, ROW_BITS = 4, HIST_W = 2, CTR_W = 2;
  localparam int ROWS = 1 << ROW_BITS, COLS = 1 << HIST_W;
  localparam int CMAX = (1 << CTR_W) - 1;
  localparam int CINIT = (1 << (CTR_W - 1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic pred_taken, upd_ready, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [HIST_W-1:0] pred_hist, upd_hist = '0;

  always #2 clk = ~clk;

  corr_bpred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .ROW_BITS(ROW_BITS),
               .HIST_W(HIST_W), .CTR_W(CTR_W)) u_corr_bpred (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  int model [ROWS][COLS];
  int mhist;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] mk_pc(input int row, input logic [31:0] junk);
    logic [PC_W-1:0] p = junk;
    p[PC_LSB +: ROW_BITS] = ROW_BITS'(row);
    return p;
  endfunction

  // One accepted update; the model follows the requirements arithmetically.
  task automatic do_upd(input int row, input int t, input int h, input logic [31:0] junk);
    @(negedge clk);
    upd_pc = mk_pc(row, junk); upd_taken = t[0]; upd_hist = HIST_W'(h); upd_valid = 1'b1;
    @(posedge clk); #1;
    upd_valid = 1'b0;
    if (t != 0) begin if (model[row][h] < CMAX) model[row][h]++; end       // R3
    else        begin if (model[row][h] > 0)    model[row][h]--; end       // R4
    mhist = ((mhist << 1) | t) & (COLS - 1);                                // R6
  endtask

  // Look up every row at the current history and compare with the model.
  task automatic sweep(input string req, input logic [31:0] junk);
    for (int r = 0; r < ROWS; r++) begin
      pred_pc = mk_pc(r, junk ^ 32'(r * 977));
      #1;
      chk(req, int'(pred_taken), int'(model[r][mhist] > CINIT));
    end
    chk("R6 history", int'(pred_hist), mhist);
  endtask

  // Bring the history to zero through a row that the caller does not read.
  task automatic steer_zero(input int row);
    for (int k = 0; k < HIST_W; k++) do_upd(row, 0, mhist, 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) model[r][c] = CINIT;
    mhist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, all rows predict not taken, history zero
    chk("R1 ready", int'(upd_ready), 1);
    sweep("R1 reset lookup", 32'hFFFF_FFF0);

    // R9: strong taken needs two not-taken outcomes to flip
    do_upd(5, 1, 0, 32'h0);
    steer_zero(9);
    do_upd(5, 1, 0, 32'h0);
    steer_zero(9);
    pred_pc = mk_pc(5, 32'h0); #1; chk("R9 strong taken", int'(pred_taken), 1);
    do_upd(5, 0, 0, 32'h0);
    steer_zero(9);
    pred_pc = mk_pc(5, 32'h0); #1; chk("R9 one miss keeps taken", int'(pred_taken), 1);
    do_upd(5, 0, 0, 32'h0);
    steer_zero(9);
    pred_pc = mk_pc(5, 32'h0); #1; chk("R9 second miss flips", int'(pred_taken), 0);
    sweep("R5 directed", 32'h0);

    // R8: inputs wiggle with valid low; nothing may change
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      upd_pc = mk_pc(k, 32'hABCD_0000); upd_taken = 1'b1; upd_hist = HIST_W'(k);
    end
    @(negedge clk);
    sweep("R8 no valid", 32'h5A5A_0000);

    // R2 R5 R7 R10: random rows, stale snapshots, random upper PC bits
    for (int s = 0; s < 800; s++) begin
      int row, t, h;
      rng = next_rng(rng); row = int'(rng[7:4]);
      rng = next_rng(rng); t = int'(rng[9]);
      rng = next_rng(rng); h = int'(rng[HIST_W+3:4]);
      rng = next_rng(rng);
      do_upd(row, t, h, rng);
      sweep("R2/R5/R7/R10 random", next_rng(rng));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule